// File: doc/BRIEF.md
# Lossless Neighbour-Prediction Rice Encoder

This block compresses a raster stream of 8-bit pixels without loss. Each interior pixel is predicted from neighbours that have already passed: the pixel above, the pixel to the left and the pixel diagonally above-left. The difference between the real value and the prediction is folded into a non-negative number, and that number is sent out as a Golomb-Rice codeword, one bit per clock. Pixels in the top row or the leftmost column are not predicted; their raw value is coded as it is.

A single row of earlier pixels is kept in a line buffer. Two predictors can be selected: a median rule that picks among the three neighbours, or the floor of the average of the pixel above and the pixel to the left. The Rice divisor exponent k is a run-time input. The quotient is produced by letting a modulo-2^k chunk counter step through the value and emitting a one for every full wrap. The pixel input is held off with a ready signal while a codeword is being shifted out. Row and frame position are tracked from start-of-frame and start-of-line flags, and a frame-done pulse marks the last bit of the final pixel.

Top module: `rice_pred_encoder`

## Requirements
- R1: While reset is asserted and until the first pixel is accepted, code_valid and frame_done are 0 and pix_ready is 1.
- R2: A pixel whose row is 0 (pix_sof) or whose column is 0 (pix_sof or pix_sol) is coded with value v equal to its raw 8-bit value.
- R3: With cfg_mode = 0, an interior pixel is predicted from up a, left b and up-left c: if c >= max(a,b) the prediction is min(a,b); if c <= min(a,b) it is max(a,b); otherwise it is a + b - c.
- R4: With cfg_mode = 1, an interior pixel is predicted as floor((a + b) / 2).
- R5: The residual e = pixel - prediction is coded as v = 2e when e >= 0 and v = -2e - 1 when e < 0.
- R6: The codeword for v is q = floor(v / 2^k) ones, then a single zero, then the k low bits of v, most significant first, with k = cfg_k.
- R7: The first bit of a codeword appears in the cycle after the pixel is accepted, and code_valid stays 1 on consecutive cycles until the last bit.
- R8: pix_ready is 0 during every bit of a codeword except its last bit, and 1 during the last bit and while idle.
- R9: code_last is 1 on the last bit of each codeword and 0 on every other bit.
- R10: frame_done is 1 exactly on the last bit of the codeword for the pixel at row cfg_height-1, column cfg_width-1, and 0 otherwise.
- R11: cfg_k is taken when a pixel is accepted; changing it while that pixel's codeword is being sent does not alter the codeword.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_width | input | COL_W+1 | Pixels per row |
| cfg_height | input | ROW_W | Rows per frame |
| cfg_k | input | K_W | Rice exponent k |
| cfg_mode | input | 1 | 0 median predictor, 1 mean predictor |
| pix_valid | input | 1 | Pixel offered |
| pix_ready | output | 1 | Pixel can be accepted |
| pix_data | input | PIX_W | Pixel value |
| pix_sof | input | 1 | Pixel is row 0, column 0 |
| pix_sol | input | 1 | Pixel is column 0 of a later row |
| code_valid | output | 1 | code_bit carries a codeword bit |
| code_bit | output | 1 | Serial codeword bit |
| code_last | output | 1 | Final bit of the codeword |
| frame_done | output | 1 | Final bit of the frame's last pixel |

## Verification
A pixel accepted at a rising edge has its first code bit due in the following cycle, and bit i of its codeword is due i cycles after that; the bench drives on falling edges and samples each bit on the falling edge of the cycle it is due, comparing the whole codeword against one computed from the pixel values in the bench. code_last, frame_done and pix_ready are checked on those same samples, so their position within the codeword is pinned to the cycle. The next pixel is offered during the last bit, so back-to-back acceptance is covered, and cfg_k is disturbed right after acceptance in one frame to show it is latched.

// File: rtl/rpe_pkg.sv
package rpe_pkg;
  typedef enum logic [1:0] {
    CODER_IDLE  = 2'd0,
    CODER_UNARY = 2'd1,
    CODER_LIT   = 2'd2
  } coder_state_e;

  typedef enum logic {
    PRED_MEDIAN = 1'b0,
    PRED_MEAN   = 1'b1
  } pred_mode_e;
endpackage

// File: rtl/rpe_line_buffer.sv
module rpe_line_buffer #(
  parameter int PIX_W = 8,
  parameter int DEPTH = 1024,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [PIX_W-1:0] wr_data,
  output logic [PIX_W-1:0] rd_data
);
  logic [PIX_W-1:0] row_mem [DEPTH];

  // read returns the value stored by the previous row at this column
  assign rd_data = row_mem[addr];

  always_ff @(posedge clk) begin
    if (wr_en) begin
      row_mem[addr] <= wr_data;
    end
  end
endmodule

// File: rtl/rpe_predictor.sv
module rpe_predictor
  import rpe_pkg::*;
#(
  parameter int PIX_W = 8,
  localparam int VAL_W = PIX_W + 1,
  localparam int RES_W = PIX_W + 2
) (
  input  logic             border,
  input  pred_mode_e       mode,
  input  logic [PIX_W-1:0] raw,
  input  logic [PIX_W-1:0] nb_up,
  input  logic [PIX_W-1:0] nb_left,
  input  logic [PIX_W-1:0] nb_diag,
  output logic [VAL_W-1:0] coded_val
);
  logic [PIX_W-1:0] hi, lo, pred_med, pred_mean, pred;
  logic [RES_W-1:0] grad, resid;
  logic [PIX_W:0]   pair_sum;
  logic [VAL_W-1:0] dbl;

  always_comb begin
    hi = (nb_up > nb_left) ? nb_up : nb_left;
    lo = (nb_up > nb_left) ? nb_left : nb_up;
    grad = {2'b00, nb_up} + {2'b00, nb_left} - {2'b00, nb_diag};
    if (nb_diag >= hi) begin
      pred_med = lo;
    end else if (nb_diag <= lo) begin
      pred_med = hi;
    end else begin
      pred_med = grad[PIX_W-1:0];
    end
    pair_sum  = {1'b0, nb_up} + {1'b0, nb_left};
    pred_mean = pair_sum[PIX_W:1];
    pred      = (mode == PRED_MEAN) ? pred_mean : pred_med;
    resid     = {2'b00, raw} - {2'b00, pred};
    dbl       = {resid[PIX_W-1:0], 1'b0};
    if (border) begin
      coded_val = {1'b0, raw};
    end else if (resid[RES_W-1]) begin
      coded_val = ~dbl;
    end else begin
      coded_val = dbl;
    end
  end
endmodule

// File: rtl/rpe_rice_coder.sv
module rpe_rice_coder
  import rpe_pkg::*;
#(
  parameter int VAL_W = 9,
  parameter int K_W   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [VAL_W-1:0] load_val,
  input  logic [K_W-1:0]   load_k,
  input  logic             load_final,
  output logic             out_valid,
  output logic             out_bit,
  output logic             out_last,
  output logic             out_frame_end
);
  coder_state_e     state_q, state_d;
  logic [VAL_W-1:0] rem_q, rem_d;
  logic [K_W-1:0]   k_q, k_d;
  logic [K_W-1:0]   idx_q, idx_d;
  logic             fin_q, fin_d;
  logic             wrap_left;
  logic [VAL_W-1:0] chunk;

  // each unary one stands for one full wrap of a modulo-2^k counter
  assign chunk     = VAL_W'(1) << k_q;
  assign wrap_left = (rem_q >> k_q) != '0;

  always_comb begin
    out_valid = (state_q != CODER_IDLE);
    out_bit   = 1'b0;
    out_last  = 1'b0;
    unique case (state_q)
      CODER_UNARY: begin
        out_bit  = wrap_left;
        out_last = !wrap_left && (k_q == '0);
      end
      CODER_LIT: begin
        out_bit  = rem_q[idx_q];
        out_last = (idx_q == '0);
      end
      default: ;
    endcase
    out_frame_end = out_last && fin_q;
  end

  always_comb begin
    state_d = state_q;
    rem_d   = rem_q;
    k_d     = k_q;
    idx_d   = idx_q;
    fin_d   = fin_q;
    unique case (state_q)
      CODER_UNARY: begin
        if (wrap_left) begin
          rem_d = rem_q - chunk;
        end else if (k_q == '0) begin
          state_d = CODER_IDLE;
        end else begin
          state_d = CODER_LIT;
          idx_d   = k_q - K_W'(1);
        end
      end
      CODER_LIT: begin
        if (idx_q == '0) begin
          state_d = CODER_IDLE;
        end else begin
          idx_d = idx_q - K_W'(1);
        end
      end
      default: ;
    endcase
    if (load) begin
      state_d = CODER_UNARY;
      rem_d   = load_val;
      k_d     = load_k;
      idx_d   = '0;
      fin_d   = load_final;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= CODER_IDLE;
      rem_q   <= '0;
      k_q     <= '0;
      idx_q   <= '0;
      fin_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      rem_q   <= rem_d;
      k_q     <= k_d;
      idx_q   <= idx_d;
      fin_q   <= fin_d;
    end
  end
endmodule

// File: rtl/rice_pred_encoder.sv
module rice_pred_encoder
  import rpe_pkg::*;
#(
  parameter int PIX_W     = 8,
  parameter int MAX_WIDTH = 1024,
  parameter int ROW_W     = 12,
  parameter int K_W       = 3,
  localparam int COL_W = (MAX_WIDTH > 1) ? $clog2(MAX_WIDTH) : 1,
  localparam int DIM_W = COL_W + 1,
  localparam int VAL_W = PIX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIM_W-1:0] cfg_width,
  input  logic [ROW_W-1:0] cfg_height,
  input  logic [K_W-1:0]   cfg_k,
  input  logic             cfg_mode,
  input  logic             pix_valid,
  output logic             pix_ready,
  input  logic [PIX_W-1:0] pix_data,
  input  logic             pix_sof,
  input  logic             pix_sol,
  output logic             code_valid,
  output logic             code_bit,
  output logic             code_last,
  output logic             frame_done
);
  logic             accept;
  logic [COL_W-1:0] col_q, col_d, cur_col;
  logic [ROW_W-1:0] row_q, row_d, cur_row;
  logic [PIX_W-1:0] left_q, left_d, diag_q, diag_d, upper;
  logic             border, is_final;
  logic [VAL_W-1:0] coded_val;
  pred_mode_e       mode;

  assign accept    = pix_valid && pix_ready;
  assign pix_ready = !code_valid || code_last;
  assign mode      = pred_mode_e'(cfg_mode);

  always_comb begin
    if (pix_sof) begin
      cur_col = '0;
      cur_row = '0;
    end else if (pix_sol) begin
      cur_col = '0;
      cur_row = row_q + ROW_W'(1);
    end else begin
      cur_col = col_q + COL_W'(1);
      cur_row = row_q;
    end
    border   = (cur_row == '0) || (cur_col == '0);
    is_final = (cur_row == cfg_height - ROW_W'(1)) &&
               (DIM_W'(cur_col) == cfg_width - DIM_W'(1));
    col_d    = accept ? cur_col  : col_q;
    row_d    = accept ? cur_row  : row_q;
    left_d   = accept ? pix_data : left_q;
    diag_d   = accept ? upper    : diag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_q  <= '0;
      row_q  <= '0;
      left_q <= '0;
      diag_q <= '0;
    end else begin
      col_q  <= col_d;
      row_q  <= row_d;
      left_q <= left_d;
      diag_q <= diag_d;
    end
  end

  rpe_line_buffer #(
    .PIX_W (PIX_W),
    .DEPTH (MAX_WIDTH)
  ) u_row_store (
    .clk     (clk),
    .wr_en   (accept),
    .addr    (cur_col),
    .wr_data (pix_data),
    .rd_data (upper)
  );

  rpe_predictor #(
    .PIX_W (PIX_W)
  ) u_pred (
    .border    (border),
    .mode      (mode),
    .raw       (pix_data),
    .nb_up     (upper),
    .nb_left   (left_q),
    .nb_diag   (diag_q),
    .coded_val (coded_val)
  );

  rpe_rice_coder #(
    .VAL_W (VAL_W),
    .K_W   (K_W)
  ) u_coder (
    .clk           (clk),
    .rst_n         (rst_n),
    .load          (accept),
    .load_val      (coded_val),
    .load_k        (cfg_k),
    .load_final    (is_final),
    .out_valid     (code_valid),
    .out_bit       (code_bit),
    .out_last      (code_last),
    .out_frame_end (frame_done)
  );
endmodule

// File: rtl/rpe_checker.sv
module rpe_checker (
  input logic clk,
  input logic rst_n,
  input logic pix_valid,
  input logic pix_ready,
  input logic code_valid,
  input logic code_last,
  input logic frame_done
);
  p_ready_when_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !code_valid |-> pix_ready);

  p_ready_low_midword_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (code_valid && !code_last) |-> !pix_ready);

  p_stream_contiguous_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (code_valid && !code_last) |=> code_valid);

  p_start_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && pix_ready) |=> code_valid);

  p_done_on_last_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (code_valid && code_last));

  p_last_needs_valid_r9: assert property (@(posedge clk) disable iff (!rst_n)
    code_last |-> code_valid);
endmodule

bind rice_pred_encoder rpe_checker u_rpe_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .pix_valid  (pix_valid),
  .pix_ready  (pix_ready),
  .code_valid (code_valid),
  .code_last  (code_last),
  .frame_done (frame_done)
);

// File: tb/rice_pred_encoder_test.sv
`timescale 1ns/1ps
module rice_pred_encoder_test;
  localparam int W = 5;
  localparam int H = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [10:0] cfg_width;
  logic [11:0] cfg_height;
  logic [2:0]  cfg_k;
  logic        cfg_mode;
  logic        pix_valid;
  logic        pix_ready;
  logic [7:0]  pix_data;
  logic        pix_sof, pix_sol;
  logic        code_valid, code_bit, code_last, frame_done;

  always #2.5 clk = ~clk;

  rice_pred_encoder uut (
    .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_height(cfg_height),
    .cfg_k(cfg_k), .cfg_mode(cfg_mode), .pix_valid(pix_valid),
    .pix_ready(pix_ready), .pix_data(pix_data), .pix_sof(pix_sof),
    .pix_sol(pix_sol), .code_valid(code_valid), .code_bit(code_bit),
    .code_last(code_last), .frame_done(frame_done)
  );

  int checks = 0;
  int fails  = 0;
  int img [0:H-1][0:W-1];
  bit exp_bits [0:1023];
  int exp_len;

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, expv);
    end
  endtask

  function automatic int model_val(input int r, input int c, input int mode);
    int a, b, d, p, e, mx, mn;
    if (r == 0 || c == 0) return img[r][c];
    a = img[r-1][c]; b = img[r][c-1]; d = img[r-1][c-1];
    mx = (a > b) ? a : b;
    mn = (a > b) ? b : a;
    if (mode == 1) p = (a + b) / 2;
    else if (d >= mx) p = mn;
    else if (d <= mn) p = mx;
    else p = a + b - d;
    e = img[r][c] - p;
    return (e >= 0) ? 2 * e : -2 * e - 1;
  endfunction

  task automatic build_code(input int v, input int k);
    exp_len = 0;
    for (int i = 0; i < (v >> k); i++) begin exp_bits[exp_len] = 1'b1; exp_len++; end
    exp_bits[exp_len] = 1'b0; exp_len++;
    for (int b = k - 1; b >= 0; b--) begin exp_bits[exp_len] = bit'((v >> b) & 1); exp_len++; end
  endtask

  // called on a falling edge; returns on the falling edge of the last bit
  task automatic send(input int r, input int c, input int mode, input int k, input bit scramble);
    int mism = 0, last_bad = 0, done_bad = 0, gap = 0, rdy_bad = 0;
    bit fin;
    string tag;
    fin = (r == H - 1) && (c == W - 1);
    tag = (r == 0 || c == 0) ? "R2 R6" : (mode == 0 ? "R3 R5 R6" : "R4 R5 R6");
    if (scramble) tag = {tag, " R11"};
    build_code(model_val(r, c, mode), k);
    pix_valid = 1'b1;
    pix_data  = 8'(img[r][c]);
    pix_sof   = (r == 0 && c == 0);
    pix_sol   = (c == 0 && r > 0);
    check(pix_ready == 1'b1, "R8 ready at offer", int'(pix_ready), 1);
    @(posedge clk);
    @(negedge clk);
    pix_valid = 1'b0;
    if (scramble) cfg_k = 3'(k) ^ 3'd5;
    for (int i = 0; i < exp_len; i++) begin
      if (!code_valid) begin gap++; break; end
      if (code_bit != exp_bits[i]) mism++;
      if (code_last != (i == exp_len - 1)) last_bad++;
      if (frame_done != (fin && i == exp_len - 1)) done_bad++;
      if (pix_ready != (i == exp_len - 1)) rdy_bad++;
      if (i < exp_len - 1) @(negedge clk);
    end
    cfg_k = 3'(k);
    check(mism == 0 && gap == 0, tag, mism, 0);
    check(gap == 0, "R7 contiguous bits", gap, 0);
    check(last_bad == 0, "R9 code_last position", last_bad, 0);
    check(done_bad == 0, "R10 frame_done position", done_bad, 0);
    check(rdy_bad == 0, "R8 ready during codeword", rdy_bad, 0);
  endtask

  task automatic run_frame(input int mode, input int k, input int pat, input bit scramble);
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++)
        case (pat)
          0: img[r][c] = (r * 37 + c * 11) % 256;
          1: img[r][c] = int'($urandom_range(0, 255));
          default: img[r][c] = ((r + c) % 2 == 0) ? 255 : 0;
        endcase
    cfg_mode = 1'(mode);
    cfg_k    = 3'(k);
    for (int r = 0; r < H; r++)
      for (int c = 0; c < W; c++)
        send(r, c, mode, k, scramble);
    @(negedge clk);
    check(code_valid == 1'b0 && frame_done == 1'b0, "R7 R10 idle after frame",
          int'(code_valid) + int'(frame_done), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired act=0 exp=1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; cfg_width = 11'(W); cfg_height = 12'(H); cfg_k = 3'd0;
    cfg_mode = 1'b0; pix_valid = 1'b0; pix_data = '0; pix_sof = 1'b0; pix_sol = 1'b0;
    repeat (3) @(negedge clk);
    check(code_valid == 1'b0 && frame_done == 1'b0 && pix_ready == 1'b1, "R1 in reset",
          int'(code_valid) + int'(frame_done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(code_valid == 1'b0 && frame_done == 1'b0 && pix_ready == 1'b1, "R1 after reset",
          int'(code_valid) + int'(frame_done) + int'(!pix_ready), 0);
    for (int mode = 0; mode < 2; mode++)
      for (int k = 0; k < 5; k++)
        for (int pat = 0; pat < 3; pat++)
          run_frame(mode, k, pat, 1'b0);
    run_frame(0, 2, 1, 1'b1);
    run_frame(1, 7, 0, 1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule